// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Unit

This block keeps the completion and fault state of one DMA channel and raises the channel interrupt. The data path reports each bus-cycle termination. For each one it gives a valid strobe, an error flag, a direction flag (read or write) and a flag that marks the last cycle of the transfer. The unit records separate fault flags for reads and writes. On any fault it stops the channel and marks it done. A fault on a write also drops whatever the internal holding register still contains.

Software reads a 4-bit status word and an interrupt-enable bit. Writing a 1 to the done position of the status word clears done and both fault flags in one step, and that also removes the interrupt. A new channel start is refused while a fault flag is still pending. Bus data movement and arbitration are handled elsewhere.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, status_o (bit0 done, bit1 read fault, bit2 write fault, bit3 busy), hold_valid_o, int_en_o, irq_o and halt_o are all 0.
- R2: A termination with term_err_i=1 and term_write_i=0 sets status bit1 and bit0 and clears bit3 on the next cycle. Bit2 is left unchanged.
- R3: A termination with term_err_i=1 and term_write_i=1 sets status bit2 and bit0, clears bit3 and clears hold_valid_o on the next cycle.
- R4: halt_o is 1 exactly while status bit1 or bit2 is set. While halt_o is 1, start_i is ignored and bit3 stays 0.
- R5: A fault-free termination with term_last_i=1 sets bit0 and clears bit3. A fault-free termination with term_last_i=0 leaves the status unchanged.
- R6: start_i with halt_o=0 sets status bit3 on the next cycle.
- R7: irq_o equals int_en_o AND status bit0. int_en_o takes ctl_ie_i on each cycle where ctl_wr_i=1.
- R8: stat_wr_i with stat_wdata_i bit0=1 clears status bits 0, 1 and 2 on the next cycle. Bit3 is unaffected.
- R9: stat_wr_i with stat_wdata_i bit0=0 changes no status bit.
- R10: When a status-setting termination and a clear arrive in the same cycle, the bits set by the termination end up set.
- R11: hold_load_i sets hold_valid_o and hold_drain_i clears it. A write fault overrides both. A read fault leaves hold_valid_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Channel start request |
| term_valid_i | input | 1 | Bus cycle terminated this cycle |
| term_err_i | input | 1 | Termination was a bus fault |
| term_write_i | input | 1 | Terminated cycle was a write |
| term_last_i | input | 1 | Terminated cycle completes the transfer |
| hold_load_i | input | 1 | Holding register loaded by a read |
| hold_drain_i | input | 1 | Holding register emptied by a write |
| stat_wr_i | input | 1 | Software write to status word |
| stat_wdata_i | input | 4 | Status write data; bit0 is the clear command |
| ctl_wr_i | input | 1 | Software write to control bit |
| ctl_ie_i | input | 1 | Interrupt-enable value to store |
| status_o | output | 4 | {busy, write fault, read fault, done} |
| hold_valid_o | output | 1 | Holding register contains data |
| halt_o | output | 1 | Channel stopped by a fault |
| int_en_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Channel interrupt |

## Verification
The assertions assume that term_err_i, term_write_i and term_last_i carry meaning only while term_valid_i is high. They also assume that the stored status and enable bits change only through the inputs named in the requirements. The bench drives every input from a 16-bit LFSR and keeps faults and clears at a lower rate. This lets halted, cleared and restarted episodes alternate, and it often puts a termination and a clear in the same cycle. Every input pattern stays legal by construction, because the unit accepts any combination. The direction and last flags are simply don't-care when term_valid_i is low.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int STAT_W   = 4;
  localparam int DONE_BIT = 0;
  localparam int RERR_BIT = 1;
  localparam int WERR_BIT = 2;
  localparam int BUSY_BIT = 3;

  typedef struct packed {
    logic busy;
    logic werr;
    logic rerr;
    logic done;
  } stat_t;
endpackage

// File: rtl/dma_stat_flags.sv
module dma_stat_flags
  import dma_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  term_valid_i,
  input  logic  term_err_i,
  input  logic  term_write_i,
  input  logic  term_last_i,
  input  logic  clr_i,
  output stat_t stat_o,
  output logic  halt_o,
  output logic  werr_ev_o
);
  stat_t q, d;
  logic  rerr_ev, done_ev, start_ok;

  assign rerr_ev   = term_valid_i & term_err_i & ~term_write_i;
  assign werr_ev_o = term_valid_i & term_err_i & term_write_i;
  assign done_ev   = (term_valid_i & term_err_i) | (term_valid_i & ~term_err_i & term_last_i);
  assign halt_o    = q.rerr | q.werr;
  assign start_ok  = start_i & ~halt_o;

  // set beats clear, per bit
  always_comb begin
    d.done = done_ev   | (q.done & ~clr_i);
    d.rerr = rerr_ev   | (q.rerr & ~clr_i);
    d.werr = werr_ev_o | (q.werr & ~clr_i);
    d.busy = (q.busy | start_ok) & ~done_ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign stat_o = q;
endmodule

// File: rtl/dma_stat_hold.sv
module dma_stat_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic drain_i,
  input  logic discard_i,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_o <= 1'b0;
    else if (discard_i) valid_o <= 1'b0;
    else if (load_i)    valid_o <= 1'b1;
    else if (drain_i)   valid_o <= 1'b0;
  end
endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic ctl_ie_i,
  input  logic done_i,
  output logic ie_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ie_o <= 1'b0;
    else if (ctl_wr_i) ie_o <= ctl_ie_i;
  end

  assign irq_o = ie_o & done_i;
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          term_valid_i,
  input  logic          term_err_i,
  input  logic          term_write_i,
  input  logic          term_last_i,
  input  logic          hold_load_i,
  input  logic          hold_drain_i,
  input  logic          stat_wr_i,
  input  logic [SW-1:0] stat_wdata_i,
  input  logic          ctl_wr_i,
  input  logic          ctl_ie_i,
  output logic [SW-1:0] status_o,
  output logic          hold_valid_o,
  output logic          halt_o,
  output logic          int_en_o,
  output logic          irq_o
);
  stat_t stat;
  logic  clr, werr_ev;

  assign clr = stat_wr_i & stat_wdata_i[DONE_BIT];

  dma_stat_flags u_flags (
    .clk_i, .rst_ni, .start_i, .term_valid_i, .term_err_i, .term_write_i,
    .term_last_i, .clr_i(clr), .stat_o(stat), .halt_o, .werr_ev_o(werr_ev)
  );

  dma_stat_hold u_hold (
    .clk_i, .rst_ni, .load_i(hold_load_i), .drain_i(hold_drain_i),
    .discard_i(werr_ev), .valid_o(hold_valid_o)
  );

  dma_stat_irq u_irq (
    .clk_i, .rst_ni, .ctl_wr_i, .ctl_ie_i, .done_i(stat.done),
    .ie_o(int_en_o), .irq_o
  );

  assign status_o = SW'(stat);
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       term_valid_i,
  input logic       term_err_i,
  input logic       term_write_i,
  input logic       stat_wr_i,
  input logic [3:0] stat_wdata_i,
  input logic [3:0] status_o,
  input logic       hold_valid_o,
  input logic       halt_o,
  input logic       int_en_o,
  input logic       irq_o
);
  a_r2_read_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_valid_i && term_err_i && !term_write_i |=> status_o[1] && status_o[0] && !status_o[3]);

  a_r3_write_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_valid_i && term_err_i && term_write_i |=> status_o[2] && status_o[0] && !hold_valid_o);

  a_r4_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && start_i |=> !status_o[3]);

  a_r7_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (int_en_o && status_o[0]));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && stat_wdata_i[0] && !term_valid_i |=> status_o[2:0] == 3'b000);

  a_r9_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && !stat_wdata_i[0] && !term_valid_i |=> $stable(status_o[2:0]));

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && stat_wdata_i[0] && term_valid_i && term_err_i |=> status_o[0]);
endmodule

bind dma_chan_status dma_chan_status_chk u_chk (
  .clk_i, .rst_ni, .start_i, .term_valid_i, .term_err_i, .term_write_i,
  .stat_wr_i, .stat_wdata_i, .status_o, .hold_valid_o, .halt_o, .int_en_o, .irq_o
);

// File: tb/tb_dma_chan_status.sv
module tb_dma_chan_status;
  localparam time TCLK = 10ns;
  localparam int  SWEEP = 4000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i, term_valid_i, term_err_i, term_write_i, term_last_i;
  logic hold_load_i, hold_drain_i, stat_wr_i, ctl_wr_i, ctl_ie_i;
  logic [3:0] stat_wdata_i, status_o;
  logic hold_valid_o, halt_o, int_en_o, irq_o;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // model state
  logic md, mre, mwe, mb, mh, mie;

  always #(TCLK/2) clk_i = ~clk_i;

  dma_chan_status dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    start_i = 0; term_valid_i = 0; term_err_i = 0; term_write_i = 0; term_last_i = 0;
    hold_load_i = 0; hold_drain_i = 0; stat_wr_i = 0; stat_wdata_i = '0;
    ctl_wr_i = 0; ctl_ie_i = 0;
  endtask

  // apply current inputs for one edge, update model, return at negedge
  task automatic step();
    logic ferr, rset, wset, dset, clr, sok;
    ferr = term_valid_i & term_err_i;
    rset = ferr & ~term_write_i;
    wset = ferr & term_write_i;
    dset = ferr | (term_valid_i & ~term_err_i & term_last_i);
    clr  = stat_wr_i & stat_wdata_i[0];
    sok  = start_i & ~(mre | mwe);
    @(posedge clk_i);
    mb  = (mb | sok) & ~dset;
    md  = dset | (md & ~clr);
    mre = rset | (mre & ~clr);
    mwe = wset | (mwe & ~clr);
    mh  = wset ? 1'b0 : hold_load_i ? 1'b1 : hold_drain_i ? 1'b0 : mh;
    if (ctl_wr_i) mie = ctl_ie_i;
    @(negedge clk_i);
    idle();
  endtask

  function automatic logic [3:0] mstat();
    return {mb, mwe, mre, md};
  endfunction

  initial begin
    #(TCLK * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    idle();
    {md, mre, mwe, mb, mh, mie} = '0;
    #(TCLK * 2);
    @(negedge clk_i);
    // R1 reset state
    chk("R1", {status_o, hold_valid_o, halt_o, int_en_o, irq_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 start
    start_i = 1; step();
    chk("R6", status_o, 4'b1000);
    // R5 non-last good cycle no change
    term_valid_i = 1; step();
    chk("R5", status_o, 4'b1000);
    // R7 enable irq then complete
    ctl_wr_i = 1; ctl_ie_i = 1; hold_load_i = 1; step();
    chk("R7", {int_en_o, irq_o}, 2'b10);
    chk("R11", hold_valid_o, 1);
    term_valid_i = 1; term_last_i = 1; step();
    chk("R5", status_o, 4'b0001);
    chk("R7", irq_o, 1);
    // R9 write zero
    stat_wr_i = 1; stat_wdata_i = 4'b1110; step();
    chk("R9", status_o, 4'b0001);
    // R8 clear
    stat_wr_i = 1; stat_wdata_i = 4'b0001; step();
    chk("R8", {status_o, irq_o}, 5'b00000);
    // R2 read fault keeps hold
    start_i = 1; step();
    term_valid_i = 1; term_err_i = 1; step();
    chk("R2", status_o, 4'b0011);
    chk("R11", hold_valid_o, 1);
    chk("R4", halt_o, 1);
    // R4 start refused
    start_i = 1; step();
    chk("R4", status_o, 4'b0011);
    // R10 clear with write fault same cycle
    stat_wr_i = 1; stat_wdata_i = 4'b0001;
    term_valid_i = 1; term_err_i = 1; term_write_i = 1; step();
    chk("R10", status_o, 4'b0101);
    chk("R3", hold_valid_o, 0);
    // R3 write fault overrides load, busy cleared
    stat_wr_i = 1; stat_wdata_i = 4'b0001; step();
    chk("R8", {status_o, halt_o}, 5'b00000);
    start_i = 1; step();
    hold_load_i = 1; term_valid_i = 1; term_err_i = 1; term_write_i = 1; step();
    chk("R3", {status_o, hold_valid_o}, 5'b01010);
    chk("R7", irq_o, 1);
    // R11 drain
    stat_wr_i = 1; stat_wdata_i = 4'b0001; hold_load_i = 1; step();
    hold_drain_i = 1; step();
    chk("R11", hold_valid_o, 0);

    // sweep
    lf = 16'hACE1;
    for (int k = 0; k < SWEEP; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      term_valid_i = lf[0]; term_err_i = lf[1] & lf[2] & lf[15];
      term_write_i = lf[3]; term_last_i = lf[4] & lf[5];
      start_i = lf[6]; stat_wr_i = lf[7] & lf[8];
      stat_wdata_i = {lf[13], lf[11], lf[2], lf[9]};
      hold_load_i = lf[10]; hold_drain_i = lf[11];
      ctl_wr_i = lf[12] & lf[13] & lf[14]; ctl_ie_i = lf[14] ^ lf[1];
      step();
      chk("R2 R3 R5 R6 R8 R9 R10 status", status_o, mstat());
      chk("R4 halt", halt_o, mre | mwe);
      chk("R11 hold", hold_valid_o, mh);
      chk("R7 irq", {int_en_o, irq_o}, {mie, mie & md});
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule